// File: doc/BRIEF.md
# Configuration Register Unlock and Write Guard

This block owns an 8-bit configuration register that mixes two volatile enable latches with six bits modelled as nonvolatile storage. A byte-level front end, which decodes the serial bus, tells it when a transaction starts and stops, when a register byte has been written or the register has been read, and when the memory array is about to be written. The block decides whether each written register byte is acknowledged. It grants or refuses each array write and keeps a busy flag high while a nonvolatile update is being stored.

The nonvolatile bits change only after a guarded sequence. First the write latch is opened, then the register latch, and then a byte with the write latch bit at one and the register latch bit at zero is written and the transaction is closed with a stop. A stored value is not shown on the readable register until the next register read. A write-protect pin together with a protect-enable bit in the register locks the block-select bits and the protect-enable bit itself. The address compare that selects the protected memory range sits outside this block; only its "in protected range" result enters.

Top module: `nvcfg_lock`

## Requirements
- R1: After power-on reset `reg_o` shows the `NV_INIT` value in bits 7..3 and bit 0, bits 2 (register latch) and 1 (write latch) read 0, and `busy_o` is 0.
- R2: A written byte of 02h sets the write latch (bit 1) at once, is acknowledged, and does not raise `busy_o`.
- R3: A byte of 06h sets both latches when the write latch is already set and is acknowledged. With the write latch clear it changes nothing and is not acknowledged.
- R4: Any written byte with bit 1 at 0 clears the write latch at once, is not acknowledged, and leaves the register latch as it was.
- R5: With both latches set, a byte with bit 2 = 0 and bit 1 = 1 is acknowledged. At the next stop its bits 7..3 and 0 are stored, the register latch clears, and `busy_o` stays high for exactly `BUSY_CYC` cycles.
- R6: With both latches set, a byte with bits 2 and 1 both at 1 is acknowledged and changes neither the stored bits nor the register latch.
- R7: Stored values reach bits 7..3 and 0 of `reg_o` only at the next register read; until then the old values are shown.
- R8: A register byte written while `busy_o` is high is not acknowledged and has no effect.
- R9: When `wp_i` is high and the visible protect-enable bit (bit 7) is 1 at the time of the stop, a store keeps bits 7, 4 and 3 at their old values and updates bits 6, 5 and 0.
- R10: `mem_wr_ok_o` is high only for an array write request with the write latch set and `mem_prot_i` low. A request with `mem_prot_i` high clears the register latch.
- R11: While `hold_i` is high every strobe and request is ignored: no acknowledge, no grant, no state change.
- R12: A transaction start between the storing byte and its stop cancels the store; the register latch stays set and `busy_o` stays low.
- R13: A register read between steps of the unlock sequence does not disturb the latches or an armed store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| hold_i | input | 1 | Reset-active indication; all other inputs ignored while high |
| wp_i | input | 1 | Write-protect pin |
| xact_start_i | input | 1 | One-cycle pulse: bus transaction start |
| xact_stop_i | input | 1 | One-cycle pulse: bus transaction stop |
| reg_wr_i | input | 1 | One-cycle pulse: a register data byte has been received |
| reg_wdata_i | input | 8 | The received register byte |
| reg_rd_i | input | 1 | One-cycle pulse: the register is being read |
| mem_wr_i | input | 1 | Array write request |
| mem_prot_i | input | 1 | Request targets the protected range |
| reg_o | output | 8 | Readable register value |
| reg_ack_o | output | 1 | Acknowledge for the byte strobed in the previous cycle |
| mem_wr_ok_o | output | 1 | Array write granted (same cycle as request) |
| busy_o | output | 1 | Nonvolatile store in progress |

## Verification
The bench builds the block with `BUSY_CYC` = 8, so the whole busy window, including a register write that lands inside it and the exact cycle it ends, fits in a few bytes of stimulus. `NV_INIT` = 81h starts the part with protect-enable already set, so the locked-store case under a high write-protect pin and a reset back to the power-on value are both reachable without a long setup.

// File: rtl/nvcfg_pkg.sv
package nvcfg_pkg;

  localparam int unsigned REG_W  = 8;
  localparam int unsigned B_WPEN = 7;
  localparam int unsigned B_RWEL = 2;
  localparam int unsigned B_WEL  = 1;

  // bits held in the nonvolatile shadow: 7..3 and 0
  localparam logic [REG_W-1:0] NV_MASK   = 8'hF9;
  // bits frozen when the pin and protect-enable lock the register
  localparam logic [REG_W-1:0] LOCK_MASK = 8'h98;
  localparam logic [REG_W-1:0] CODE_WEL  = 8'h02;
  localparam logic [REG_W-1:0] CODE_RWEL = 8'h06;

  typedef enum logic [2:0] {
    CMD_IGNORE,
    CMD_DROP_WEL,
    CMD_ARM_WEL,
    CMD_ARM_RWEL,
    CMD_STORE,
    CMD_KEEP
  } cmd_e;

  function automatic cmd_e classify(input logic [REG_W-1:0] d,
                                    input logic wel,
                                    input logic rwel);
    cmd_e c;
    if (!d[B_WEL])                   c = CMD_DROP_WEL;
    else if (wel && rwel)            c = d[B_RWEL] ? CMD_KEEP : CMD_STORE;
    else if (wel && d == CODE_RWEL)  c = CMD_ARM_RWEL;
    else if (d == CODE_WEL)          c = CMD_ARM_WEL;
    else                             c = CMD_IGNORE;
    return c;
  endfunction

endpackage

// File: rtl/nvcfg_rst_sync.sv
module nvcfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/nvcfg_latch.sv
module nvcfg_latch
  import nvcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             busy,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  input  logic             start,
  input  logic             stop,
  input  logic             mem_req,
  input  logic             mem_prot,
  output logic             wel,
  output logic             rwel,
  output logic             ack,
  output logic             commit_go,
  output logic [REG_W-1:0] commit_raw
);

  logic             wel_q, wel_d;
  logic             rwel_q, rwel_d;
  logic             arm_q, arm_d;
  logic [REG_W-1:0] raw_q, raw_d;
  logic             ack_q, ack_d;
  logic             wr_live;
  logic             go;
  cmd_e             cmd;

  assign cmd     = classify(wr_data, wel_q, rwel_q);
  assign wr_live = en && wr_stb && !busy;
  assign go      = en && stop && arm_q;

  always_comb begin
    wel_d  = wel_q;
    rwel_d = rwel_q;
    arm_d  = arm_q;
    raw_d  = raw_q;
    ack_d  = 1'b0;
    if (en) begin
      if (start) arm_d = 1'b0;
      if (wr_live) begin
        unique case (cmd)
          CMD_DROP_WEL: wel_d = 1'b0;
          CMD_ARM_WEL: begin
            wel_d = 1'b1;
            ack_d = 1'b1;
          end
          CMD_ARM_RWEL: begin
            wel_d  = 1'b1;
            rwel_d = 1'b1;
            ack_d  = 1'b1;
          end
          CMD_STORE: begin
            arm_d = 1'b1;
            raw_d = wr_data;
            ack_d = 1'b1;
          end
          CMD_KEEP:   ack_d = 1'b1;
          CMD_IGNORE: ack_d = 1'b0;
          default:    ack_d = 1'b0;
        endcase
      end
      if (mem_req && mem_prot) rwel_d = 1'b0;
      if (go) begin
        arm_d  = 1'b0;
        rwel_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
      arm_q  <= 1'b0;
      raw_q  <= '0;
      ack_q  <= 1'b0;
    end else begin
      wel_q  <= wel_d;
      rwel_q <= rwel_d;
      arm_q  <= arm_d;
      raw_q  <= raw_d;
      ack_q  <= ack_d;
    end
  end

  assign wel        = wel_q;
  assign rwel       = rwel_q;
  assign ack        = ack_q;
  assign commit_go  = go;
  assign commit_raw = raw_q;

endmodule

// File: rtl/nvcfg_guard.sv
module nvcfg_guard
  import nvcfg_pkg::*;
(
  input  logic             en,
  input  logic             wp,
  input  logic             vis_wpen,
  input  logic             wel,
  input  logic             mem_req,
  input  logic             mem_prot,
  input  logic [REG_W-1:0] new_val,
  input  logic [REG_W-1:0] old_val,
  output logic [REG_W-1:0] merged,
  output logic             mem_ok
);

  logic locked;

  assign locked = wp && vis_wpen;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (!NV_MASK[i]) begin : g_vol
      assign merged[i] = 1'b0;
    end else if (LOCK_MASK[i]) begin : g_lock
      assign merged[i] = locked ? old_val[i] : new_val[i];
    end else begin : g_free
      assign merged[i] = new_val[i];
    end
  end

  assign mem_ok = en && mem_req && wel && !mem_prot;

endmodule

// File: rtl/nvcfg_store.sv
module nvcfg_store
  import nvcfg_pkg::*;
#(
  parameter logic [REG_W-1:0] NV_INIT  = 8'h00,
  parameter int unsigned      BUSY_CYC = 2_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             commit_go,
  input  logic [REG_W-1:0] commit_val,
  input  logic             rd_stb,
  output logic [REG_W-1:0] stored,
  output logic [REG_W-1:0] visible,
  output logic             busy
);

  localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [REG_W-1:0] INIT_NV = NV_INIT & NV_MASK;

  logic [REG_W-1:0] nv_q, nv_d;
  logic [REG_W-1:0] vis_q, vis_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    nv_d  = nv_q;
    vis_d = vis_q;
    cnt_d = cnt_q;
    if (commit_go)          nv_d  = commit_val;
    if (en && rd_stb)       vis_d = nv_q;
    if (commit_go)          cnt_d = CNT_W'(BUSY_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q  <= INIT_NV;
      vis_q <= INIT_NV;
      cnt_q <= '0;
    end else begin
      nv_q  <= nv_d;
      vis_q <= vis_d;
      cnt_q <= cnt_d;
    end
  end

  assign stored  = nv_q;
  assign visible = vis_q;
  assign busy    = (cnt_q != '0);

endmodule

// File: rtl/nvcfg_lock.sv
module nvcfg_lock
  import nvcfg_pkg::*;
#(
  parameter logic [7:0]  NV_INIT     = 8'h00,
  parameter int unsigned BUSY_CYC    = 2_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_i,
  input  logic       wp_i,
  input  logic       xact_start_i,
  input  logic       xact_stop_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  input  logic       reg_rd_i,
  input  logic       mem_wr_i,
  input  logic       mem_prot_i,
  output logic [7:0] reg_o,
  output logic       reg_ack_o,
  output logic       mem_wr_ok_o,
  output logic       busy_o
);

  logic             rst_s_n;
  logic             en;
  logic             wel, rwel, busy, go;
  logic [REG_W-1:0] raw, merged, stored, visible;

  assign en = !hold_i;

  nvcfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  nvcfg_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .en         (en),
    .busy       (busy),
    .wr_stb     (reg_wr_i),
    .wr_data    (reg_wdata_i),
    .start      (xact_start_i),
    .stop       (xact_stop_i),
    .mem_req    (mem_wr_i),
    .mem_prot   (mem_prot_i),
    .wel        (wel),
    .rwel       (rwel),
    .ack        (reg_ack_o),
    .commit_go  (go),
    .commit_raw (raw)
  );

  nvcfg_guard u_guard (
    .en       (en),
    .wp       (wp_i),
    .vis_wpen (visible[B_WPEN]),
    .wel      (wel),
    .mem_req  (mem_wr_i),
    .mem_prot (mem_prot_i),
    .new_val  (raw),
    .old_val  (stored),
    .merged   (merged),
    .mem_ok   (mem_wr_ok_o)
  );

  nvcfg_store #(.NV_INIT(NV_INIT), .BUSY_CYC(BUSY_CYC)) u_store (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .en         (en),
    .commit_go  (go),
    .commit_val (merged),
    .rd_stb     (reg_rd_i),
    .stored     (stored),
    .visible    (visible),
    .busy       (busy)
  );

  assign reg_o  = {visible[7:3], rwel, wel, visible[0]};
  assign busy_o = busy;

endmodule

// File: rtl/nvcfg_lock_chk.sv
module nvcfg_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_i,
  input logic       xact_stop_i,
  input logic       reg_wr_i,
  input logic       reg_rd_i,
  input logic       mem_wr_i,
  input logic       mem_prot_i,
  input logic [7:0] reg_o,
  input logic       reg_ack_o,
  input logic       mem_wr_ok_o,
  input logic       busy_o
);

  AST_ACK_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ack_o |-> $past(reg_wr_i)); // R2

  AST_NO_ACK_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ack_o |-> !$past(busy_o)); // R8

  AST_NO_ACK_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ack_o |-> !$past(hold_i)); // R11

  AST_GRANT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_ok_o |-> (reg_o[1] && !mem_prot_i && !hold_i)); // R10

  AST_RWEL_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_o[2]) |-> ($past(xact_stop_i) || $past(mem_wr_i && mem_prot_i))); // R5

  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(xact_stop_i)); // R5

  AST_NV_VIEW_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd_i) |-> ($stable(reg_o[7:3]) && $stable(reg_o[0]))); // R7

endmodule

bind nvcfg_lock nvcfg_lock_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_i      (hold_i),
  .xact_stop_i (xact_stop_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .mem_wr_i    (mem_wr_i),
  .mem_prot_i  (mem_prot_i),
  .reg_o       (reg_o),
  .reg_ack_o   (reg_ack_o),
  .mem_wr_ok_o (mem_wr_ok_o),
  .busy_o      (busy_o)
);

// File: tb/sim_nvcfg_lock.sv
`timescale 1ns/1ps
module sim_nvcfg_lock;

  localparam int unsigned BUSY = 8;
  localparam logic [7:0]  INIT = 8'h81;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hold_i, wp_i, xact_start_i, xact_stop_i;
  logic       reg_wr_i, reg_rd_i, mem_wr_i, mem_prot_i;
  logic [7:0] reg_wdata_i;
  logic [7:0] reg_o;
  logic       reg_ack_o, mem_wr_ok_o, busy_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  nvcfg_lock #(.NV_INIT(INIT), .BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .wp_i(wp_i),
    .xact_start_i(xact_start_i), .xact_stop_i(xact_stop_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rd_i(reg_rd_i),
    .mem_wr_i(mem_wr_i), .mem_prot_i(mem_prot_i),
    .reg_o(reg_o), .reg_ack_o(reg_ack_o), .mem_wr_ok_o(mem_wr_ok_o), .busy_o(busy_o)
  );

  // row: op(2) data(8) expected reg(8) expected ack(1) requirement(4)
  // op 0 write, 1 read, 2 stop, 3 idle 16 cycles
  localparam int NROW = 13;
  localparam logic [22:0] ROWS [NROW] = '{
    {2'd0, 8'h00, 8'h81, 1'b0, 4'd4},   // R4 drop write latch
    {2'd0, 8'h06, 8'h81, 1'b0, 4'd3},   // R3 06h without write latch
    {2'd0, 8'h02, 8'h83, 1'b1, 4'd2},   // R2 open write latch
    {2'd1, 8'h00, 8'h83, 1'b0, 4'd13},  // R13 read between steps
    {2'd0, 8'h06, 8'h87, 1'b1, 4'd3},   // R3 open register latch
    {2'd1, 8'h00, 8'h87, 1'b0, 4'd13},  // R13 read between steps
    {2'd0, 8'h56, 8'h87, 1'b1, 4'd6},   // R6 bit2 set keeps state
    {2'd0, 8'h52, 8'h87, 1'b1, 4'd5},   // R5 store byte armed
    {2'd2, 8'h00, 8'h83, 1'b0, 4'd7},   // R7 old view after stop
    {2'd1, 8'h00, 8'h52, 1'b0, 4'd7},   // R7 new view after read
    {2'd0, 8'h02, 8'h52, 1'b0, 4'd8},   // R8 write during busy
    {2'd3, 8'h00, 8'h52, 1'b0, 4'd8},   // R8 nothing changed
    {2'd0, 8'h00, 8'h50, 1'b0, 4'd4}    // R4 drop write latch
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk); reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk); reg_wr_i = 1'b0;
  endtask
  task automatic pulse_rd();
    @(negedge clk); reg_rd_i = 1'b1;
    @(negedge clk); reg_rd_i = 1'b0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); xact_stop_i = 1'b1;
    @(negedge clk); xact_stop_i = 1'b0;
  endtask
  task automatic pulse_start();
    @(negedge clk); xact_start_i = 1'b1;
    @(negedge clk); xact_start_i = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic mem_try(input logic prot, output logic ok);
    @(negedge clk); mem_wr_i = 1'b1; mem_prot_i = prot;
    #1 ok = mem_wr_ok_o;
    @(negedge clk); mem_wr_i = 1'b0; mem_prot_i = 1'b0;
  endtask
  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic ok;
    hold_i = 0; wp_i = 0; xact_start_i = 0; xact_stop_i = 0;
    reg_wr_i = 0; reg_wdata_i = 0; reg_rd_i = 0; mem_wr_i = 0; mem_prot_i = 0;
    do_reset();

    // R1 power-on state
    chk("R1 reg", reg_o, INIT & 8'hF9);
    chk("R1 busy", {7'd0, busy_o}, 8'h00);
    chk("R1 ack", {7'd0, reg_ack_o}, 8'h00);

    for (int i = 0; i < NROW; i++) begin
      logic [22:0] r;
      string tag;
      r = ROWS[i];
      case (r[22:21])
        2'd0: pulse_wr(r[20:13]);
        2'd1: pulse_rd();
        2'd2: pulse_stop();
        default: idle(16);
      endcase
      tag = $sformatf("R%0d row %0d", r[3:0], i);
      chk({tag, " reg"}, reg_o, r[12:5]);
      chk({tag, " ack"}, {7'd0, reg_ack_o}, {7'd0, r[4]});
    end

    // R5 store of zeros and exact busy length
    pulse_wr(8'h02); pulse_wr(8'h06); pulse_wr(8'h02);
    pulse_stop();
    chk("R5 busy start", {7'd0, busy_o}, 8'h01);
    chk("R5 rwel cleared", reg_o, 8'h52);
    for (int k = 1; k < BUSY; k++) begin
      @(negedge clk);
      chk("R5 busy held", {7'd0, busy_o}, 8'h01);
    end
    @(negedge clk);
    chk("R5 busy end", {7'd0, busy_o}, 8'h00);
    pulse_rd();
    chk("R7 zeros visible", reg_o, 8'h02);

    // R9 locked store keeps protect-enable and block bits
    pulse_wr(8'h06); pulse_wr(8'h9A); pulse_stop(); idle(BUSY + 2);
    pulse_rd();
    chk("R9 setup", reg_o, 8'h9A);
    wp_i = 1'b1;
    pulse_wr(8'h06); pulse_wr(8'h62); pulse_stop(); idle(BUSY + 2);
    pulse_rd();
    chk("R9 locked store", reg_o, 8'hFA);

    // R10 array write grants and register-latch clearing
    mem_try(1'b0, ok); chk("R10 unprot grant", {7'd0, ok}, 8'h01);
    mem_try(1'b1, ok); chk("R10 prot refuse", {7'd0, ok}, 8'h00);
    pulse_wr(8'h06);
    chk("R10 rwel set", reg_o, 8'hFE);
    mem_try(1'b1, ok);
    chk("R10 rwel cleared", reg_o, 8'hFA);
    pulse_wr(8'h00);
    mem_try(1'b0, ok); chk("R10 no wel refuse", {7'd0, ok}, 8'h00);

    // R12 start cancels an armed store
    wp_i = 1'b0;
    pulse_wr(8'h02); pulse_wr(8'h06); pulse_wr(8'h02);
    pulse_start(); pulse_stop();
    chk("R12 no busy", {7'd0, busy_o}, 8'h00);
    pulse_rd();
    chk("R12 unchanged", reg_o, 8'hFE);

    // R11 hold ignores everything
    hold_i = 1'b1;
    pulse_wr(8'h00);
    chk("R11 reg", reg_o, 8'hFE);
    chk("R11 ack", {7'd0, reg_ack_o}, 8'h00);
    mem_try(1'b0, ok); chk("R11 grant", {7'd0, ok}, 8'h00);
    hold_i = 1'b0;

    // R1 reset restores power-on value
    do_reset();
    chk("R1 after reset", reg_o, INIT & 8'hF9);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule